// File: doc/BRIEF.md
# Power Gating Sequence Controller

This block steps a switchable power domain off and back on. A power-down request turns on the domain's isolation first and opens the power switch after that. A power-up request reverses the order: it closes the switch first and then releases isolation. Each of the four gaps between these events is a clock count that software programs. While a sequence runs, the block ignores any request that is not the one it is waiting for.

Software reaches four 32-bit registers through a small word-addressed read/write port. One register holds an enable that decides whether a power-down request is obeyed. Two registers hold the delays. The last is a read-only status flag that records whether the most recent power-down request actually removed power. The isolation output is active high. The switch output is active low, so 0 means the domain is powered. A busy output is high while a sequence is in progress.

Top module: `pwr_gate_seq`

## Requirements
- R1: After a synchronous reset, iso_en is 0, pwr_sw_n is 0 and busy is 0, and all four registers read 0.
- R2: The register at word address 0 holds the power-down enable in bit 0. Word 1 holds the up-switch delay in bits 5:0 and the up-isolation delay in bits 13:8. Word 2 holds the down-isolation delay in bits 5:0 and the down-switch delay in bits 13:8. Word 3 holds the status in bit 0. Unused bits read 0, and a write to word 3 has no effect.
- R3: A power-down request in the powered state while the enable is 0 leaves the outputs unchanged and clears the status to 0 at the same clock edge.
- R4: A power-down request accepted at edge k raises iso_en at edge k+1+D, where D is the down-isolation delay.
- R5: pwr_sw_n rises S+1 edges after iso_en rose, where S is the down-switch delay. The status becomes 1 at that same edge.
- R6: A power-up request accepted in the off state at edge k drops pwr_sw_n at edge k+1+U, where U is the up-switch delay.
- R7: iso_en falls I+1 edges after pwr_sw_n fell, where I is the up-isolation delay. The block is then back in the powered state.
- R8: A power-up request is acted on only in the off state, and a power-down request only in the powered state. Any request that arrives while a sequence runs has no effect.
- R9: busy is 1 exactly while a power-down or power-up sequence is in progress.
- R10: The enable is sampled only when a power-down request is accepted. Rewriting it during a sequence does not change that sequence.
- R11: pwr_sw_n is never 1 while iso_en is 0.
- R12: A delay of 0 moves the sequence to the next step on the next clock edge, and a delay of 63 is counted in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| pdn_req | input | 1 | Power-down request |
| pup_req | input | 1 | Power-up request |
| iso_en | output | 1 | Isolation active, high asserted |
| pwr_sw_n | output | 1 | Power switch control, 0 = domain powered |
| busy | output | 1 | A sequence is in progress |

## Verification
The conditions that are hardest to reach from the ports are the ones that occur inside a running sequence. These are a request of the wrong kind arriving during a wait, and the enable being rewritten while power is already going down. The stimulus reaches them by pulsing requests and writing the control register in the middle of programmed waits that are long enough to contain them. The same sequences are repeated with all delays at 0 and at 63, and a reference model timed from the edge that accepted each request is compared with the outputs on every clock.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int DLY_W  = 6;
    localparam int LO_POS = 0;
    localparam int HI_POS = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_UP   = 2'd1;
    localparam logic [ADDR_W-1:0] A_DN   = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    typedef enum logic [2:0] {
        ST_ON     = 3'd0,
        ST_DN_ISO = 3'd1,
        ST_DN_SW  = 3'd2,
        ST_OFF    = 3'd3,
        ST_UP_SW  = 3'd4,
        ST_UP_ISO = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic [DLY_W-1:0] up_sw;
        logic [DLY_W-1:0] up_iso;
        logic [DLY_W-1:0] dn_iso;
        logic [DLY_W-1:0] dn_sw;
    } dly_cfg_t;

    function automatic logic [DATA_W-1:0] pack_pair(input logic [DLY_W-1:0] lo,
                                                    input logic [DLY_W-1:0] hi);
        logic [DATA_W-1:0] w;
        w = '0;
        w[LO_POS +: DLY_W] = lo;
        w[HI_POS +: DLY_W] = hi;
        return w;
    endfunction

endpackage

// File: rtl/pgs_regs.sv
module pgs_regs
    import pgs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              stat_set,
    input  logic              stat_clr,
    output logic              pdn_allow,
    output dly_cfg_t          cfg
);

    logic     allow_q;
    logic     stat_q;
    dly_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            allow_q <= 1'b0;
            stat_q  <= 1'b0;
            cfg_q   <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    A_CTRL: allow_q <= wdata[0];
                    A_UP: begin
                        cfg_q.up_sw  <= wdata[LO_POS +: DLY_W];
                        cfg_q.up_iso <= wdata[HI_POS +: DLY_W];
                    end
                    A_DN: begin
                        cfg_q.dn_iso <= wdata[LO_POS +: DLY_W];
                        cfg_q.dn_sw  <= wdata[HI_POS +: DLY_W];
                    end
                    default: ;
                endcase
            end
            if (stat_set)
                stat_q <= 1'b1;
            else if (stat_clr)
                stat_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata[0] = allow_q;
            A_UP:    rdata = pack_pair(cfg_q.up_sw, cfg_q.up_iso);
            A_DN:    rdata = pack_pair(cfg_q.dn_iso, cfg_q.dn_sw);
            A_STAT:  rdata[0] = stat_q;
            default: rdata = '0;
        endcase
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata[DATA_W-1:HI_POS+DLY_W], wdata[HI_POS-1:LO_POS+DLY_W]};

    assign pdn_allow = allow_q;
    assign cfg       = cfg_q;

    // R2: status is not writable from the bus
    a_r2_status_ro: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_STAT && !stat_set && !stat_clr) |=> $stable(stat_q));

    // R3: a refused power-down clears the status
    a_r3_status_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !stat_set) |=> !stat_q);

endmodule

// File: rtl/pgs_timer.sv
module pgs_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R12: each wait step counts down by exactly one
    a_r12_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/pgs_seq.sv
module pgs_seq
    import pgs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pdn_req,
    input  logic             pup_req,
    input  logic             pdn_allow,
    input  dly_cfg_t         cfg,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [DLY_W-1:0] tmr_val,
    output logic             stat_set,
    output logic             stat_clr,
    output logic             iso_en,
    output logic             pwr_sw_n,
    output logic             busy
);

    seq_state_e state, nxt;
    logic       iso_q, swn_q;

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        stat_set = 1'b0;
        stat_clr = 1'b0;
        case (state)
            ST_ON: if (pdn_req) begin
                if (pdn_allow) begin
                    nxt      = ST_DN_ISO;
                    tmr_load = 1'b1;
                    tmr_val  = cfg.dn_iso;
                end else begin
                    stat_clr = 1'b1;
                end
            end
            ST_DN_ISO: if (tmr_done) begin
                nxt      = ST_DN_SW;
                tmr_load = 1'b1;
                tmr_val  = cfg.dn_sw;
            end
            ST_DN_SW: if (tmr_done) begin
                nxt      = ST_OFF;
                stat_set = 1'b1;
            end
            ST_OFF: if (pup_req) begin
                nxt      = ST_UP_SW;
                tmr_load = 1'b1;
                tmr_val  = cfg.up_sw;
            end
            ST_UP_SW: if (tmr_done) begin
                nxt      = ST_UP_ISO;
                tmr_load = 1'b1;
                tmr_val  = cfg.up_iso;
            end
            ST_UP_ISO: if (tmr_done) nxt = ST_ON;
            default: nxt = ST_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ON;
            iso_q <= 1'b0;
            swn_q <= 1'b0;
        end else begin
            state <= nxt;
            iso_q <= (nxt != ST_ON) && (nxt != ST_DN_ISO);
            swn_q <= (nxt == ST_OFF) || (nxt == ST_UP_SW);
        end
    end

    assign iso_en   = iso_q;
    assign pwr_sw_n = swn_q;
    assign busy     = (state != ST_ON) && (state != ST_OFF);

    // R11: switch never opens without isolation
    a_r11_iso_guard: assert property (@(posedge clk) disable iff (rst)
        pwr_sw_n |-> iso_en);

    // R8: off state is left only on a power-up request
    a_r8_hold_off: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF && !pup_req) |=> (state == ST_OFF && pwr_sw_n));

    // R8: powered state is left only on an enabled power-down request
    a_r8_hold_on: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ON && !(pdn_req && pdn_allow)) |=> (state == ST_ON && !iso_en));

    // R5: status is set at the edge the switch opens
    a_r5_status_at_off: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_sw_n) |-> $past(stat_set));

    // R9: an idle power-down step raises busy
    a_r9_busy_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ON && pdn_req && pdn_allow) |=> busy);

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
    import pgs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pdn_req,
    input  logic              pup_req,
    output logic              iso_en,
    output logic              pwr_sw_n,
    output logic              busy
);

    dly_cfg_t         cfg;
    logic             pdn_allow;
    logic             stat_set, stat_clr;
    logic             tmr_load, tmr_done;
    logic [DLY_W-1:0] tmr_val;

    pgs_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .stat_set  (stat_set),
        .stat_clr  (stat_clr),
        .pdn_allow (pdn_allow),
        .cfg       (cfg)
    );

    pgs_timer #(.W(DLY_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pgs_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .pdn_req   (pdn_req),
        .pup_req   (pup_req),
        .pdn_allow (pdn_allow),
        .cfg       (cfg),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .stat_set  (stat_set),
        .stat_clr  (stat_clr),
        .iso_en    (iso_en),
        .pwr_sw_n  (pwr_sw_n),
        .busy      (busy)
    );

endmodule

// File: tb/pwr_gate_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_gate_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        pdn_req = 1'b0;
    logic        pup_req = 1'b0;
    logic        iso_en, pwr_sw_n, busy;

    always #4 clk = ~clk;

    pwr_gate_seq dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pdn_req(pdn_req),
        .pup_req(pup_req), .iso_en(iso_en), .pwr_sw_n(pwr_sw_n), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    // reference model: event times are computed from the edge that accepted a request
    int cyc = 0;
    int ph = 0;             // 0 powered, 1 going down, 2 off, 3 coming up
    int t1 = -1, t2 = -1;
    bit m_iso, m_swn, m_busy, m_stat, m_allow;
    int m_usw, m_uiso, m_diso, m_dsw;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            ph = 0; t1 = -1; t2 = -1;
            m_iso = 0; m_swn = 0; m_busy = 0; m_stat = 0; m_allow = 0;
            m_usw = 0; m_uiso = 0; m_diso = 0; m_dsw = 0;
        end else begin
            case (ph)
                0: if (pdn_req) begin
                    if (m_allow) begin ph = 1; t1 = cyc + 1 + m_diso; t2 = -1; end
                    else m_stat = 0;
                end
                1: if (cyc == t1) begin m_iso = 1; t2 = cyc + 1 + m_dsw; end
                   else if (cyc == t2) begin m_swn = 1; m_stat = 1; ph = 2; end
                2: if (pup_req) begin ph = 3; t1 = cyc + 1 + m_usw; t2 = -1; end
                3: if (cyc == t1) begin m_swn = 0; t2 = cyc + 1 + m_uiso; end
                   else if (cyc == t2) begin m_iso = 0; ph = 0; end
                default: ph = 0;
            endcase
            m_busy = (ph == 1) || (ph == 3);
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: m_allow = bus_wdata[0];
                    2'd1: begin m_usw = bus_wdata[5:0]; m_uiso = bus_wdata[13:8]; end
                    2'd2: begin m_diso = bus_wdata[5:0]; m_dsw = bus_wdata[13:8]; end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison with the model
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk(iso_en == m_iso, "R4 R7 R10 R12 iso_en", {31'd0, iso_en}, {31'd0, m_iso});
            chk(pwr_sw_n == m_swn, "R5 R6 R8 R12 pwr_sw_n", {31'd0, pwr_sw_n}, {31'd0, m_swn});
            chk(busy == m_busy, "R9 busy", {31'd0, busy}, {31'd0, m_busy});
            chk(!(pwr_sw_n && !iso_en), "R11 ordering", {30'd0, pwr_sw_n, iso_en}, 32'd3);
        end
    end

    function automatic logic [31:0] word_of(input int a);
        case (a)
            0: return {31'd0, m_allow};
            1: return (32'(m_uiso) << 8) | 32'(m_usw);
            2: return (32'(m_dsw) << 8) | 32'(m_diso);
            default: return {31'd0, m_stat};
        endcase
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input string tag);
        @(negedge clk); bus_addr = a; #1;
        chk(bus_rdata == word_of(int'(a)), tag, bus_rdata, word_of(int'(a)));
    endtask

    task automatic rd_exp(input logic [1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); bus_addr = a; #1;
        chk(bus_rdata == e, tag, bus_rdata, e);
    endtask

    task automatic pulse_pdn();
        @(negedge clk); pdn_req = 1; @(negedge clk); pdn_req = 0;
    endtask

    task automatic pulse_pup();
        @(negedge clk); pup_req = 1; @(negedge clk); pup_req = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && m_busy; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cmp_on = 1;
        @(negedge clk);
        // R1 reset state
        chk(!iso_en && !pwr_sw_n && !busy, "R1 outputs", {29'd0, iso_en, pwr_sw_n, busy}, 32'd0);
        for (int a = 0; a < 4; a++) rd_exp(2'(a), 32'd0, "R1 register reset");

        // R2 field placement and masking
        wr(2'd1, 32'hFFFF_FFFF);
        rd_exp(2'd1, 32'h0000_3F3F, "R2 up register mask");
        wr(2'd2, 32'h0000_1234);
        rd_exp(2'd2, 32'h0000_1234, "R2 down register fields");
        wr(2'd0, 32'hFFFF_FFFE);
        rd_exp(2'd0, 32'd0, "R2 control bit0 only");
        wr(2'd3, 32'hFFFF_FFFF);
        rd_exp(2'd3, 32'd0, "R2 status write ignored");

        // R3 power-down refused while disabled
        pulse_pdn();
        repeat (4) @(negedge clk);
        chk(!iso_en && !pwr_sw_n, "R3 no change", {30'd0, iso_en, pwr_sw_n}, 32'd0);

        // R4 R5 down with delays, R8 stray requests, R10 enable rewritten mid-sequence
        wr(2'd1, 32'h0000_0402);
        wr(2'd2, 32'h0000_0503);
        wr(2'd0, 32'd1);
        pulse_pdn();
        pulse_pup();
        wr(2'd0, 32'd0);
        pulse_pdn();
        wait_idle();
        chk(pwr_sw_n && iso_en, "R10 sequence finished", {30'd0, pwr_sw_n, iso_en}, 32'd3);
        rd_exp(2'd3, 32'd1, "R5 status set");
        rd_chk(2'd0, "R10 enable readback");

        // R8 power-down in off state ignored
        pulse_pdn();
        repeat (3) @(negedge clk);
        chk(pwr_sw_n && !busy, "R8 pdn in off", {30'd0, pwr_sw_n, busy}, 32'd2);

        // R6 R7 up with a stray power-down mid-sequence
        pulse_pup();
        pulse_pdn();
        wait_idle();
        chk(!pwr_sw_n && !iso_en, "R7 powered again", {30'd0, pwr_sw_n, iso_en}, 32'd0);

        // R3 refused request clears status
        pulse_pdn();
        @(negedge clk);
        rd_exp(2'd3, 32'd0, "R3 status cleared");

        // R8 power-up in powered state ignored
        pulse_pup();
        repeat (3) @(negedge clk);
        chk(!iso_en && !busy, "R8 pup in on", {30'd0, iso_en, busy}, 32'd0);

        // R12 zero delays
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd1);
        pulse_pdn(); wait_idle();
        repeat (2) @(negedge clk);
        pulse_pup(); wait_idle();
        repeat (2) @(negedge clk);

        // R12 maximum delays, request held high
        wr(2'd1, 32'h0000_3F3F);
        wr(2'd2, 32'h0000_3F3F);
        @(negedge clk); pdn_req = 1;
        repeat (140) @(negedge clk);
        pdn_req = 0;
        chk(pwr_sw_n, "R12 max down done", {31'd0, pwr_sw_n}, 32'd1);
        @(negedge clk); pup_req = 1;
        repeat (140) @(negedge clk);
        pup_req = 0;
        chk(!pwr_sw_n && !iso_en, "R12 max up done", {30'd0, pwr_sw_n, iso_en}, 32'd0);
        rd_exp(2'd3, 32'd1, "R5 status after max");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule